// File: doc/BRIEF.md
# Processor Sequencing Control Unit

This block is the state machine that steps a small accumulator-based 8-bit core through its instruction cycle. After reset it sits in an idle start state for one clock. It then enters fetch, where the instruction word is captured and the program counter advances. Next comes a decode state that reads the 3-bit opcode field. Decode branches to one execute state per opcode, and every execute state returns to fetch. The outputs are the control strobes that steer the datapath: ALU function, accumulator-input mux, register loads, register-file read/write and the branch mux.

The strobes are Moore-style. Each one is a function of the current state only, with one exception: the conditional-branch state also looks at the accumulator-is-zero flag. The block carries no data stream. Every pin is a plain control or status signal, so there is no handshake. The current state code is brought out so that the datapath, or a bench, can observe the sequence.

Top module: `proc_ctl_fsm`

## Requirements
- R1: While `rst` is high the state is START (code 0) and every strobe is 0; reset acts without waiting for a clock edge.
- R2: START (0) is followed by FETCH (1), and FETCH is followed by DECODE (2), on consecutive clock edges.
- R3: From DECODE the next state code is 8 + `opcode`. The opcodes are 000 store, 001 load, 010 move-immediate, 011 input, 100 output, 101 branch-if-nonzero, 110 add and 111 subtract.
- R4: Every execute state (codes 8 to 15) is followed by FETCH.
- R5: In FETCH, `ir_load` and `pc_load` are 1 and all other strobes are 0.
- R6: In START and DECODE all strobes are 0.
- R7: The store state (8) asserts `rf_we` with `alu_sel`=00 (pass the accumulator) and `amux_sel`=00.
- R8: The load state (9) asserts `acc_we` and `rf_re` with `amux_sel`=01 (register file). The move-immediate state (10) asserts `acc_we` with `amux_sel`=10 (immediate).
- R9: The input state (11) asserts `rf_we` with `amux_sel`=11 (input port).
- R10: The output state (12) asserts `out_load` and `rf_re`.
- R11: In the branch state (13), if `acc_zero` is 0 then `pc_load` and `jmp_sel` are both 1. If `acc_zero` is 1, both are 0.
- R12: The add state (14) asserts `acc_we` and `rf_re` with `alu_sel`=01. The subtract state (15) does the same with `alu_sel`=11; `amux_sel`=00 in both.
- R13: `opnd_fetch` is 1 in every execute state and 0 in every other state. Any strobe not named for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 3 | Opcode field of the instruction register |
| acc_zero | input | 1 | High when the accumulator equals zero |
| alu_sel | output | 2 | ALU function: 00 pass, 01 add, 11 subtract |
| amux_sel | output | 2 | Accumulator-input mux: 00 ALU, 01 register file, 10 immediate, 11 input port |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Program counter load |
| out_load | output | 1 | Output register load |
| jmp_sel | output | 1 | Selects the relative branch target for the PC |
| opnd_fetch | output | 1 | Operand field in use by the current execute state |
| rf_we | output | 1 | Register-file write enable |
| acc_we | output | 1 | Accumulator write enable |
| rf_re | output | 1 | Register-file read enable |
| state | output | 4 | Current state code |

## Verification
The assertions assume that `opcode` and `acc_zero` are stable across each rising edge and that `rst` is released away from the clock edge. The dispatch check relies on the opcode seen one cycle earlier. The bench changes inputs only on the falling edge and compares outputs just after that, so the values an edge captures are always settled. Random opcodes and zero flags, drawn from a fixed seed, are mixed with a directed sweep of all eight opcodes under both flag values and with a reset asserted mid-instruction.

// File: rtl/ctl_fsm_pkg.sv
package ctl_fsm_pkg;
  localparam int OPC_W = 3;
  localparam int ST_W  = OPC_W + 1;

  typedef enum logic [ST_W-1:0] {
    ST_START  = 4'd0,
    ST_FETCH  = 4'd1,
    ST_DECODE = 4'd2,
    ST_STORE  = 4'd8,
    ST_LOAD   = 4'd9,
    ST_IMM    = 4'd10,
    ST_IN     = 4'd11,
    ST_OUT    = 4'd12,
    ST_BNZ    = 4'd13,
    ST_ADD    = 4'd14,
    ST_SUB    = 4'd15
  } state_e;

  localparam logic [1:0] ALU_PASS = 2'b00;
  localparam logic [1:0] ALU_ADD  = 2'b01;
  localparam logic [1:0] ALU_SUB  = 2'b11;

  localparam logic [1:0] AMUX_ALU = 2'b00;
  localparam logic [1:0] AMUX_RF  = 2'b01;
  localparam logic [1:0] AMUX_IMM = 2'b10;
  localparam logic [1:0] AMUX_IN  = 2'b11;

  typedef struct packed {
    logic [1:0] alu_sel;
    logic [1:0] amux_sel;
    logic       ir_load;
    logic       pc_load;
    logic       out_load;
    logic       jmp_sel;
    logic       opnd_fetch;
    logic       rf_we;
    logic       acc_we;
    logic       rf_re;
  } strobe_t;
endpackage

// File: rtl/ctl_next_state.sv
module ctl_next_state
  import ctl_fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output state_e           state_q
);
  state_e state_n;

  always_comb begin
    unique case (state_q)
      ST_START:  state_n = ST_FETCH;
      ST_FETCH:  state_n = ST_DECODE;
      ST_DECODE: state_n = state_e'({1'b1, opcode});
      default:   state_n = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= ST_START;
    else     state_q <= state_n;
  end

  p_start_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START) |=> (state_q == ST_FETCH));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  p_decode_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE) |=> (state_q == state_e'({1'b1, $past(opcode)})));

  p_exec_returns_r4: assert property (@(posedge clk) disable iff (rst)
    state_q[ST_W-1] |=> (state_q == ST_FETCH));
endmodule

// File: rtl/ctl_strobe_dec.sv
module ctl_strobe_dec
  import ctl_fsm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  state_e  state_q,
  input  logic    acc_zero,
  output strobe_t strb
);
  always_comb begin
    strb = '0;
    strb.opnd_fetch = state_q[ST_W-1];
    unique case (state_q)
      ST_FETCH: begin
        strb.ir_load = 1'b1;
        strb.pc_load = 1'b1;
      end
      ST_STORE: begin
        strb.alu_sel  = ALU_PASS;
        strb.amux_sel = AMUX_ALU;
        strb.rf_we    = 1'b1;
      end
      ST_LOAD: begin
        strb.amux_sel = AMUX_RF;
        strb.rf_re    = 1'b1;
        strb.acc_we   = 1'b1;
      end
      ST_IMM: begin
        strb.amux_sel = AMUX_IMM;
        strb.acc_we   = 1'b1;
      end
      ST_IN: begin
        strb.amux_sel = AMUX_IN;
        strb.rf_we    = 1'b1;
      end
      ST_OUT: begin
        strb.rf_re    = 1'b1;
        strb.out_load = 1'b1;
      end
      ST_BNZ: begin
        strb.jmp_sel = !acc_zero;
        strb.pc_load = !acc_zero;
      end
      ST_ADD: begin
        strb.alu_sel  = ALU_ADD;
        strb.amux_sel = AMUX_ALU;
        strb.rf_re    = 1'b1;
        strb.acc_we   = 1'b1;
      end
      ST_SUB: begin
        strb.alu_sel  = ALU_SUB;
        strb.amux_sel = AMUX_ALU;
        strb.rf_re    = 1'b1;
        strb.acc_we   = 1'b1;
      end
      default: ;
    endcase
  end

  p_fetch_loads_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |-> (strb.ir_load && strb.pc_load && !strb.rf_we && !strb.acc_we));

  p_quiet_states_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START || state_q == ST_DECODE) |-> (strb == '0));

  p_branch_taken_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BNZ && !acc_zero) |-> (strb.pc_load && strb.jmp_sel));

  p_branch_held_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BNZ && acc_zero) |-> (!strb.pc_load && !strb.jmp_sel));

  p_single_writer_r13: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.rf_we, strb.acc_we, strb.out_load, strb.ir_load}) <= 1);

  p_ir_only_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    strb.ir_load |-> (state_q == ST_FETCH));
endmodule

// File: rtl/proc_ctl_fsm.sv
module proc_ctl_fsm
  import ctl_fsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc_zero,
  output logic [1:0]       alu_sel,
  output logic [1:0]       amux_sel,
  output logic             ir_load,
  output logic             pc_load,
  output logic             out_load,
  output logic             jmp_sel,
  output logic             opnd_fetch,
  output logic             rf_we,
  output logic             acc_we,
  output logic             rf_re,
  output logic [ST_W-1:0]  state
);
  state_e  st;
  strobe_t s;

  ctl_next_state u_next (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .state_q (st)
  );

  ctl_strobe_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .state_q  (st),
    .acc_zero (acc_zero),
    .strb     (s)
  );

  assign alu_sel    = s.alu_sel;
  assign amux_sel   = s.amux_sel;
  assign ir_load    = s.ir_load;
  assign pc_load    = s.pc_load;
  assign out_load   = s.out_load;
  assign jmp_sel    = s.jmp_sel;
  assign opnd_fetch = s.opnd_fetch;
  assign rf_we      = s.rf_we;
  assign acc_we     = s.acc_we;
  assign rf_re      = s.rf_re;
  assign state      = st;
endmodule

// File: tb/proc_ctl_fsm_tb.sv
`timescale 1ns/100ps
module proc_ctl_fsm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] opcode = 3'd0;
  logic acc_zero = 1'b0;
  logic [1:0] alu_sel, amux_sel;
  logic ir_load, pc_load, out_load, jmp_sel, opnd_fetch, rf_we, acc_we, rf_re;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_st;
  logic [3:0] prev_st;

  always #2.5 clk = ~clk;

  proc_ctl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .acc_zero(acc_zero),
    .alu_sel(alu_sel), .amux_sel(amux_sel), .ir_load(ir_load), .pc_load(pc_load),
    .out_load(out_load), .jmp_sel(jmp_sel), .opnd_fetch(opnd_fetch), .rf_we(rf_we),
    .acc_we(acc_we), .rf_re(rf_re), .state(state)
  );

  // order: alu_sel, amux_sel, ir_load, pc_load, out_load, jmp_sel, opnd_fetch, rf_we, acc_we, rf_re
  function automatic logic [11:0] exp_strobes(input logic [3:0] s, input logic z);
    logic [11:0] v;
    v = 12'd0;
    case (s)
      4'd1:  v = {2'b00, 2'b00, 8'b1100_0000};
      4'd8:  v = {2'b00, 2'b00, 8'b0000_1100};
      4'd9:  v = {2'b00, 2'b01, 8'b0000_1011};
      4'd10: v = {2'b00, 2'b10, 8'b0000_1010};
      4'd11: v = {2'b00, 2'b11, 8'b0000_1100};
      4'd12: v = {2'b00, 2'b00, 8'b0010_1001};
      4'd13: v = z ? {4'b0, 8'b0000_1000} : {4'b0, 8'b0101_1000};
      4'd14: v = {2'b01, 2'b00, 8'b0000_1011};
      4'd15: v = {2'b11, 2'b00, 8'b0000_1011};
      default: v = 12'd0;
    endcase
    return v;
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [2:0] o);
    if (s == 4'd0) return 4'd1;
    if (s == 4'd1) return 4'd2;
    if (s == 4'd2) return {1'b1, o};
    return 4'd1;
  endfunction

  function automatic string st_tag(input logic [3:0] p);
    if (p == 4'd2) return "R3";
    if (p[3]) return "R4";
    return "R2";
  endfunction

  function automatic string sb_tag(input logic [3:0] s);
    case (s)
      4'd0, 4'd2: return "R6";
      4'd1: return "R5";
      4'd8: return "R7 R13";
      4'd9, 4'd10: return "R8 R13";
      4'd11: return "R9 R13";
      4'd12: return "R10 R13";
      4'd13: return "R11 R13";
      default: return "R12 R13";
    endcase
  endfunction

  task automatic check_now(input string tst, input string tsb);
    logic [11:0] got, want;
    got  = {alu_sel, amux_sel, ir_load, pc_load, out_load, jmp_sel, opnd_fetch, rf_we, acc_we, rf_re};
    want = exp_strobes(exp_st, acc_zero);
    checks++;
    if (state !== exp_st) begin
      errors++;
      $display("FAIL %s state actual=%0d expected=%0d", tst, state, exp_st);
    end
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s strobes in state %0d actual=%b expected=%b", tsb, exp_st, got, want);
    end
  endtask

  // called just after a falling edge
  task automatic step(input logic [2:0] o, input logic z);
    opcode = o;
    acc_zero = z;
    #1;
    check_now(st_tag(prev_st), sb_tag(exp_st));
    @(posedge clk);
    prev_st = exp_st;
    exp_st = exp_next(exp_st, o);
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    exp_st = 4'd0;
    prev_st = 4'd0;
    repeat (3) @(negedge clk);
    #1;
    check_now("R1", "R1");
    rst = 1'b0;
    @(negedge clk);
    // the edge after release took START to FETCH
    prev_st = 4'd0;
    exp_st = 4'd1;
    // directed sweep: every opcode with both zero-flag values
    for (int o = 0; o < 8; o++) begin
      for (int z = 0; z < 2; z++) begin
        repeat (3) step(o[2:0], z[0]);
      end
    end
    // reset in the middle of an instruction (R1 asynchronous)
    step(3'd6, 1'b0);
    rst = 1'b1;
    #1;
    exp_st = 4'd0;
    check_now("R1", "R1");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_now("R1", "R1");
    @(negedge clk);
    prev_st = 4'd0;
    exp_st = 4'd1;
    // random stream
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(7, 0), 1'($urandom_range(1, 0)));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule